// File: doc/BRIEF.md
# Dual-Channel Measurement Cross-Check and Recovery Sequencer

This block watches two independent measurement channels that sample the same current, each delivering signed samples with its own valid strobe. It flags an upset in two ways. The first is a disagreement between the channels that persists. The second is a channel whose readings cannot be physical, because a value lies outside a configured range or jumps further than a slew limit between consecutive samples.

An upset starts a recovery on the measurement card. The first response resets the digital filters while the DAC output is held frozen, so the converter keeps running undisturbed. A settling period follows, during which all checks are masked. If another upset arrives soon after a filter reset, the block escalates to a power cycle of the card. This power cycle turns the DAC off and removes card power for part of that time. Saturating counters record how many recoveries of each kind have been issued.

All durations are set in milliseconds, together with a parameter that gives the number of clock cycles per millisecond. The defaults are a 3 ms filter reset, 10 ms of settling, 1 ms with card power removed inside a 2 ms DAC-off period, and a 1000 ms escalation window.

Top module: `meas_guard`

## Requirements
- R1: While rst_ni is low, filt_rst_o, dac_freeze_o, dac_off_o, mismatch_o and implaus_o are 0, card_pwr_en_o is 1, and both counters are 0.
- R2: In the idle state, a valid sample on a channel is implausible when it is below range_lo_i or above range_hi_i, with signed comparison. A value equal to either bound passes. The channel's bit of implaus_o (bit 0 for a, bit 1 for b) is 1 for the one cycle after the clock edge that captures the sample.
- R3: In the idle state, a valid sample is also implausible when its absolute difference from the previous valid sample of the same channel exceeds slew_lim_i. A difference equal to the limit passes. No slew test is made on the first sample after reset or after any recovery.
- R4: A paired sample has both valid strobes high in the same cycle. mismatch_o pulses for one cycle after the 4th consecutive paired sample whose channel difference exceeds diff_lim_i. A paired sample within the limit restarts the count. A sample on only one channel neither advances nor restarts it.
- R5: Any flagged condition seen while idle, with no filter reset started in the last WIN_MS*MS_CYC cycles, raises filt_rst_o and dac_freeze_o for FILT_MS*MS_CYC cycles, starting right after the capturing edge.
- R6: After a filter reset or a power cycle, dac_freeze_o stays high for SETTLE_MS*MS_CYC cycles with filt_rst_o low. Outside the idle state, samples raise no flag and start no recovery.
- R7: A flagged condition seen while idle, within WIN_MS*MS_CYC cycles after the edge that started a filter reset, starts a power cycle instead of a filter reset. A power cycle clears this window.
- R8: A power cycle holds dac_off_o high for OFF_MS*MS_CYC cycles and card_pwr_en_o low for the first CARD_MS*MS_CYC of them, then enters settling.
- R9: filt_cnt_o and pwr_cnt_o count the recoveries started of each kind and hold at their all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_valid_i | input | 1 | Channel a sample strobe |
| a_data_i | input | DATA_W | Channel a sample, signed |
| b_valid_i | input | 1 | Channel b sample strobe |
| b_data_i | input | DATA_W | Channel b sample, signed |
| diff_lim_i | input | DATA_W | Largest allowed channel difference, unsigned |
| slew_lim_i | input | DATA_W | Largest allowed step per channel, unsigned |
| range_lo_i | input | DATA_W | Lowest plausible value, signed |
| range_hi_i | input | DATA_W | Highest plausible value, signed |
| filt_rst_o | output | 1 | Digital filter reset |
| dac_freeze_o | output | 1 | Hold DAC output at its last value |
| dac_off_o | output | 1 | Turn DAC output off |
| card_pwr_en_o | output | 1 | Measurement card power enable |
| mismatch_o | output | 1 | Channel disagreement pulse |
| implaus_o | output | 2 | Implausible sample pulse per channel |
| filt_cnt_o | output | CNT_W | Filter resets issued, saturating |
| pwr_cnt_o | output | CNT_W | Power cycles issued, saturating |

## Verification
Every result is due in the cycle after the rising edge that captures the offending sample. The flag pulses, the change in the recovery outputs and the counter step all appear together after that edge. Each stage then lasts its exact parameterised cycle count. The bench drives inputs on the falling edge and advances an integer model on the rising edge. Because no output has a combinational path from an input, it compares every output on the next falling edge, one edge-count after the capture. This fixes stage lengths and window boundaries to the cycle.

// File: rtl/meas_guard_pkg.sv
package meas_guard_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_FILT,
    SEQ_SETTLE,
    SEQ_PWR
  } seq_state_e;

  // |a-b| for operands up to 32 bits, one extra bit so no wrap
  function automatic logic [32:0] abs_diff(input logic signed [31:0] a,
                                           input logic signed [31:0] b);
    logic signed [32:0] d;
    d = {a[31], a} - {b[31], b};
    return d[32] ? 33'(-d) : 33'(d);
  endfunction

endpackage

// File: rtl/chan_check.sv
module chan_check
  import meas_guard_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     mask_i,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] data_i,
  input  logic        [DATA_W-1:0] slew_lim_i,
  input  logic signed [DATA_W-1:0] range_lo_i,
  input  logic signed [DATA_W-1:0] range_hi_i,
  output logic                     bad_o
);

  logic signed [DATA_W-1:0] prev_q;
  logic                     have_q;
  logic [32:0]              step;
  logic                     out_rng;
  logic                     too_fast;

  always_comb begin
    step     = abs_diff(32'(data_i), 32'(prev_q));
    out_rng  = (data_i < range_lo_i) || (data_i > range_hi_i);
    too_fast = have_q && (step > {1'b0, 32'(slew_lim_i)});
    bad_o    = valid_i && !mask_i && (out_rng || too_fast);
  end

  // history dropped while masked: first sample after recovery has no slew test
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      have_q <= 1'b0;
    end else if (mask_i) begin
      have_q <= 1'b0;
    end else if (valid_i) begin
      prev_q <= data_i;
      have_q <= 1'b1;
    end
  end

  // R3
  no_history_when_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mask_i) |-> !have_q);

endmodule

// File: rtl/pair_check.sv
module pair_check
  import meas_guard_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int RUN_LEN = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     mask_i,
  input  logic                     a_valid_i,
  input  logic signed [DATA_W-1:0] a_data_i,
  input  logic                     b_valid_i,
  input  logic signed [DATA_W-1:0] b_data_i,
  input  logic        [DATA_W-1:0] diff_lim_i,
  output logic                     hit_o
);

  localparam int RUN_W = $clog2(RUN_LEN + 1);

  logic [RUN_W-1:0] run_q;
  logic             paired;
  logic             far;

  always_comb begin
    paired = a_valid_i && b_valid_i && !mask_i;
    far    = abs_diff(32'(a_data_i), 32'(b_data_i)) > {1'b0, 32'(diff_lim_i)};
    hit_o  = paired && far && (run_q == RUN_W'(RUN_LEN - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
    end else if (mask_i) begin
      run_q <= '0;
    end else if (paired) begin
      if (!far)                              run_q <= '0;
      else if (run_q != RUN_W'(RUN_LEN))     run_q <= run_q + 1'b1;
    end
  end

  // R4
  hit_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> !hit_o);

endmodule

// File: rtl/recovery_seq.sv
module recovery_seq
  import meas_guard_pkg::*;
#(
  parameter int FILT_CYC   = 375000,
  parameter int SETTLE_CYC = 1250000,
  parameter int PWR_CYC    = 250000,
  parameter int CARD_CYC   = 125000,
  parameter int WIN_CYC    = 125000000,
  parameter int CNT_W      = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fault_i,
  output logic             idle_o,
  output logic             filt_rst_o,
  output logic             dac_freeze_o,
  output logic             dac_off_o,
  output logic             card_pwr_en_o,
  output logic [CNT_W-1:0] filt_cnt_o,
  output logic [CNT_W-1:0] pwr_cnt_o
);

  localparam int MAX_FS  = (FILT_CYC > SETTLE_CYC) ? FILT_CYC : SETTLE_CYC;
  localparam int TMR_MAX = (MAX_FS > PWR_CYC) ? MAX_FS : PWR_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int WIN_W   = $clog2(WIN_CYC + 1);

  seq_state_e       state_q, state_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic [WIN_W-1:0] win_cnt_q;
  logic             win_run_q;
  logic             enter_filt, enter_pwr;
  logic [CNT_W-1:0] filt_cnt_q, pwr_cnt_q;

  always_comb begin
    state_d    = state_q;
    tmr_d      = tmr_q + 1'b1;
    enter_filt = 1'b0;
    enter_pwr  = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        tmr_d = '0;
        if (fault_i) begin
          if (win_run_q) begin
            state_d   = SEQ_PWR;
            enter_pwr = 1'b1;
          end else begin
            state_d    = SEQ_FILT;
            enter_filt = 1'b1;
          end
        end
      end
      SEQ_FILT: if (tmr_q == TMR_W'(FILT_CYC - 1)) begin
        state_d = SEQ_SETTLE;
        tmr_d   = '0;
      end
      SEQ_SETTLE: if (tmr_q == TMR_W'(SETTLE_CYC - 1)) begin
        state_d = SEQ_IDLE;
        tmr_d   = '0;
      end
      SEQ_PWR: if (tmr_q == TMR_W'(PWR_CYC - 1)) begin
        state_d = SEQ_SETTLE;
        tmr_d   = '0;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      tmr_q   <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
    end
  end

  // escalation window measured from the edge that started the last filter reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_cnt_q <= '0;
      win_run_q <= 1'b0;
    end else if (enter_filt) begin
      win_cnt_q <= '0;
      win_run_q <= 1'b1;
    end else if (enter_pwr) begin
      win_run_q <= 1'b0;
    end else if (win_run_q) begin
      if (win_cnt_q == WIN_W'(WIN_CYC - 1)) win_run_q <= 1'b0;
      else                                  win_cnt_q <= win_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_cnt_q <= '0;
      pwr_cnt_q  <= '0;
    end else begin
      if (enter_filt && (filt_cnt_q != {CNT_W{1'b1}})) filt_cnt_q <= filt_cnt_q + 1'b1;
      if (enter_pwr  && (pwr_cnt_q  != {CNT_W{1'b1}})) pwr_cnt_q  <= pwr_cnt_q + 1'b1;
    end
  end

  assign idle_o        = (state_q == SEQ_IDLE);
  assign filt_rst_o    = (state_q == SEQ_FILT);
  assign dac_freeze_o  = (state_q == SEQ_FILT) || (state_q == SEQ_SETTLE);
  assign dac_off_o     = (state_q == SEQ_PWR);
  assign card_pwr_en_o = !((state_q == SEQ_PWR) && (tmr_q < TMR_W'(CARD_CYC)));
  assign filt_cnt_o    = filt_cnt_q;
  assign pwr_cnt_o     = pwr_cnt_q;

  // R5
  filt_needs_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(filt_rst_o) |-> $past(fault_i));

  // R6
  settle_follows_filt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(filt_rst_o) |-> dac_freeze_o);

  // R8
  card_off_with_dac_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(card_pwr_en_o) |-> $rose(dac_off_o));

  // R9
  filt_cnt_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    filt_cnt_o >= $past(filt_cnt_o));

  // R9
  pwr_cnt_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_cnt_o >= $past(pwr_cnt_o));

endmodule

// File: rtl/meas_guard.sv
module meas_guard
  import meas_guard_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 8,
  parameter int RUN_LEN   = 4,
  parameter int MS_CYC    = 125000,
  parameter int FILT_MS   = 3,
  parameter int SETTLE_MS = 10,
  parameter int CARD_MS   = 1,
  parameter int OFF_MS    = 2,
  parameter int WIN_MS    = 1000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     a_valid_i,
  input  logic signed [DATA_W-1:0] a_data_i,
  input  logic                     b_valid_i,
  input  logic signed [DATA_W-1:0] b_data_i,
  input  logic        [DATA_W-1:0] diff_lim_i,
  input  logic        [DATA_W-1:0] slew_lim_i,
  input  logic signed [DATA_W-1:0] range_lo_i,
  input  logic signed [DATA_W-1:0] range_hi_i,
  output logic                     filt_rst_o,
  output logic                     dac_freeze_o,
  output logic                     dac_off_o,
  output logic                     card_pwr_en_o,
  output logic                     mismatch_o,
  output logic [1:0]               implaus_o,
  output logic [CNT_W-1:0]         filt_cnt_o,
  output logic [CNT_W-1:0]         pwr_cnt_o
);

  localparam int N_CH       = 2;
  localparam int FILT_CYC   = FILT_MS * MS_CYC;
  localparam int SETTLE_CYC = SETTLE_MS * MS_CYC;
  localparam int CARD_CYC   = CARD_MS * MS_CYC;
  localparam int PWR_CYC    = OFF_MS * MS_CYC;
  localparam int WIN_CYC    = WIN_MS * MS_CYC;

  logic                     seq_idle;
  logic                     pair_hit;
  logic                     fault;
  logic [N_CH-1:0]          ch_v;
  logic signed [DATA_W-1:0] ch_d [N_CH];
  logic [N_CH-1:0]          ch_bad;
  logic                     mismatch_q;
  logic [N_CH-1:0]          implaus_q;

  assign ch_v[0] = a_valid_i;
  assign ch_v[1] = b_valid_i;
  assign ch_d[0] = a_data_i;
  assign ch_d[1] = b_data_i;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    chan_check #(.DATA_W(DATA_W)) u_chk (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .mask_i     (!seq_idle),
      .valid_i    (ch_v[g]),
      .data_i     (ch_d[g]),
      .slew_lim_i (slew_lim_i),
      .range_lo_i (range_lo_i),
      .range_hi_i (range_hi_i),
      .bad_o      (ch_bad[g])
    );
  end

  pair_check #(.DATA_W(DATA_W), .RUN_LEN(RUN_LEN)) u_pair (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mask_i     (!seq_idle),
    .a_valid_i  (a_valid_i),
    .a_data_i   (a_data_i),
    .b_valid_i  (b_valid_i),
    .b_data_i   (b_data_i),
    .diff_lim_i (diff_lim_i),
    .hit_o      (pair_hit)
  );

  assign fault = pair_hit || (|ch_bad);

  recovery_seq #(
    .FILT_CYC   (FILT_CYC),
    .SETTLE_CYC (SETTLE_CYC),
    .PWR_CYC    (PWR_CYC),
    .CARD_CYC   (CARD_CYC),
    .WIN_CYC    (WIN_CYC),
    .CNT_W      (CNT_W)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fault_i       (fault),
    .idle_o        (seq_idle),
    .filt_rst_o    (filt_rst_o),
    .dac_freeze_o  (dac_freeze_o),
    .dac_off_o     (dac_off_o),
    .card_pwr_en_o (card_pwr_en_o),
    .filt_cnt_o    (filt_cnt_o),
    .pwr_cnt_o     (pwr_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mismatch_q <= 1'b0;
      implaus_q  <= '0;
    end else begin
      mismatch_q <= pair_hit;
      implaus_q  <= ch_bad;
    end
  end

  assign mismatch_o = mismatch_q;
  assign implaus_o  = implaus_q;

  // R6
  flags_only_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mismatch_o || (|implaus_o)) |-> $past(seq_idle));

  // R5
  flag_starts_recovery_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mismatch_o || (|implaus_o)) |-> (filt_rst_o || dac_off_o));

endmodule

// File: tb/meas_guard_test.sv
module meas_guard_test;

  localparam int DW = 16, CW = 2, MS = 8;
  localparam int FILT = 3 * MS, SETTLE = 10 * MS, CARD = 1 * MS, OFF = 2 * MS, WIN = 100 * MS;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic av = 1'b0, bv = 1'b0;
  logic signed [DW-1:0] ad = '0, bd = '0;
  logic [DW-1:0] dlim = 16'd100, slim = 16'd500;
  logic signed [DW-1:0] lo = -16'sd20000, hi = 16'sd20000;
  logic filt_rst, freeze, dac_off, pwr_en, mm;
  logic [1:0] imp;
  logic [CW-1:0] fcnt, pcnt;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  meas_guard #(.DATA_W(DW), .CNT_W(CW), .MS_CYC(MS), .WIN_MS(100)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .a_valid_i(av), .a_data_i(ad), .b_valid_i(bv), .b_data_i(bd),
    .diff_lim_i(dlim), .slew_lim_i(slim), .range_lo_i(lo), .range_hi_i(hi),
    .filt_rst_o(filt_rst), .dac_freeze_o(freeze), .dac_off_o(dac_off),
    .card_pwr_en_o(pwr_en), .mismatch_o(mm), .implaus_o(imp),
    .filt_cnt_o(fcnt), .pwr_cnt_o(pcnt)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int iabs(input int x);
    return x < 0 ? -x : x;
  endfunction

  // behavioural reference: mode 0 idle, 1 filter reset, 2 settle, 3 power cycle
  int n = 0, mode = 0, t0 = 0, last_f = -1, run = 0;
  int ap = 0, bp = 0;
  bit ah = 0, bh = 0;
  int e_fc = 0, e_pc = 0;
  bit e_mm = 0;
  bit [1:0] e_imp = 0;

  always @(posedge clk) begin
    if (rst_ni) begin
      bit fault, ia, ib, m;
      int a, b;
      a = int'(ad); b = int'(bd);
      n++;
      fault = 0; ia = 0; ib = 0; m = 0;
      if (mode == 0) begin
        if (av) ia = (a < int'(lo)) || (a > int'(hi)) || (ah && iabs(a - ap) > int'(slim));
        if (bv) ib = (b < int'(lo)) || (b > int'(hi)) || (bh && iabs(b - bp) > int'(slim));
        if (av && bv) begin
          if (iabs(a - b) > int'(dlim)) begin run++; m = (run == 4); end
          else run = 0;
        end
        if (av) begin ap = a; ah = 1; end
        if (bv) begin bp = b; bh = 1; end
        fault = ia || ib || m;
      end else begin
        ah = 0; bh = 0; run = 0;
      end
      e_mm = m; e_imp = {ib, ia};
      if (mode == 0 && fault) begin
        if (last_f >= 0 && n - last_f <= WIN) begin
          mode = 3; last_f = -1; if (e_pc < 3) e_pc++;
        end else begin
          mode = 1; last_f = n; if (e_fc < 3) e_fc++;
        end
        t0 = n;
      end else if (mode == 1 && n - t0 == FILT) begin mode = 2; t0 = n; end
      else if (mode == 2 && n - t0 == SETTLE) mode = 0;
      else if (mode == 3 && n - t0 == OFF) begin mode = 2; t0 = n; end
    end
  end

  // compare every output once per cycle, away from the rising edge
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      bit xf, xz, xo, xp;
      xf = (mode == 1);
      xz = (mode == 1) || (mode == 2);
      xo = (mode == 3);
      xp = !((mode == 3) && (n - t0 < CARD));
      chk(filt_rst == xf, "R5", "filt_rst_o", filt_rst, xf);
      chk(freeze == xz, "R6", "dac_freeze_o", freeze, xz);
      chk(dac_off == xo, "R8", "dac_off_o", dac_off, xo);
      chk(pwr_en == xp, "R8", "card_pwr_en_o", pwr_en, xp);
      chk(mm == e_mm, "R4", "mismatch_o", mm, e_mm);
      chk(imp == e_imp, "R2 R3", "implaus_o", imp, e_imp);
      chk(int'(fcnt) == e_fc, "R9", "filt_cnt_o", fcnt, e_fc);
      chk(int'(pcnt) == e_pc, "R7", "pwr_cnt_o", pcnt, e_pc);
    end
  end

  task automatic put(input bit va, input int a, input bit vb, input int b);
    @(negedge clk);
    av = va; ad = DW'(a); bv = vb; bd = DW'(b);
    @(negedge clk);
    av = 0; bv = 0;
  endtask

  task automatic wait_cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    wait_cyc(3);
    // R1 reset state
    chk(!filt_rst && !freeze && !dac_off && !mm && imp == 0, "R1", "outputs in reset", filt_rst | freeze | dac_off, 0);
    chk(pwr_en == 1'b1, "R1", "card_pwr_en_o in reset", pwr_en, 1);
    chk(fcnt == 0 && pcnt == 0, "R1", "counters in reset", fcnt + pcnt, 0);
    rst_ni = 1'b1;
    wait_cyc(2);

    // tracking ramp, no fault expected
    for (int i = 0; i < 20; i++) put(1, i * 50, 1, i * 50);
    // R2 R3 R4 boundaries: a equals hi, diff equals limit, step equals 50
    hi = 16'sd1000;
    put(1, 1000, 1, 900);
    wait_cyc(2);
    chk(fcnt == 0 && !freeze, "R2", "value at bound passes", fcnt, 0);
    hi = 16'sd20000;
    put(1, 1500, 0, 0);
    wait_cyc(2);
    chk(!freeze, "R3", "step equal to slew limit passes", freeze, 0);
    put(1, 1000, 0, 0);

    // R4: run broken by near pair, unpaired sample leaves run intact
    for (int i = 0; i < 3; i++) put(1, 1000, 1, 1150);
    put(1, 1000, 1, 1050);
    for (int i = 0; i < 3; i++) put(1, 1000, 1, 1150);
    put(1, 1000, 0, 0);
    wait_cyc(1);
    chk(fcnt == 0, "R4", "no recovery before 4th far pair", fcnt, 0);
    @(negedge clk); av = 1; ad = 16'sd1000; bv = 1; bd = 16'sd1150;
    @(negedge clk); av = 0; bv = 0;
    chk(mm == 1'b1 && filt_rst == 1'b1, "R4", "mismatch starts filter reset", mm, 1);
    // R6: samples during recovery are ignored
    for (int i = 0; i < 5; i++) put(1, -30000, 1, 30000);
    wait_cyc(FILT + SETTLE);
    chk(fcnt == 1 && pcnt == 0 && !freeze, "R5", "one filter reset then idle", fcnt, 1);

    // R2: range fault after window expiry gives filter reset
    wait_cyc(WIN);
    put(1, 0, 1, -25000);
    chk(filt_rst == 1'b1 && fcnt == 2, "R2", "range fault filter reset", fcnt, 2);
    wait_cyc(FILT + SETTLE + 2);
    // R3: first sample after recovery skips slew test
    put(1, 5000, 0, 0);
    wait_cyc(1);
    chk(!freeze && !dac_off, "R3", "first sample after recovery not slew tested", freeze, 0);
    // R7: slew fault within window escalates
    put(1, 7000, 0, 0);
    chk(dac_off == 1'b1 && pcnt == 1 && fcnt == 2, "R7", "escalation to power cycle", pcnt, 1);
    wait_cyc(OFF + SETTLE + 2);
    chk(pwr_en && !dac_off && !freeze, "R8", "power cycle completes", pwr_en, 1);

    // R9: saturation of both counters
    for (int k = 0; k < 3; k++) begin
      put(1, 0, 1, -25000);
      wait_cyc(FILT + SETTLE + 2);
      put(1, 0, 1, -25000);
      wait_cyc(OFF + SETTLE + 2);
    end
    chk(fcnt == 2'd3, "R9", "filt count saturates", fcnt, 3);
    chk(pcnt == 2'd3, "R9", "pwr count saturates", pcnt, 3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule